// File: doc/BRIEF.md
# SPI Receive Packing FIFO with Trailing Flush

This block sits on the receive side of an SPI controller, between the serial shifter and the parallel bus. Each received item has a programmed channel width. The block packs consecutive items into entries of the programmed bus width, with the first item in the lowest byte lanes. It holds those entries in a 64-byte store. The fill level is reported in bytes. When that level reaches a programmable trigger, the block raises either an interrupt-ready line or a DMA request. The DMA request can be qualified for single transfers or for four-beat bursts.

A stream can stop before the trigger is reached. For that case a trailing counter is reloaded by every received item. It counts down while data is waiting below the trigger. When it runs out, any partly packed entry is pushed, zero-padded, and ready or request is held until the store drains. Writing to a full store and reading an empty one both raise sticky error flags.

The configuration must stay static while the block holds data.

Top module: `spi_rx_fifo`

## Requirements
- R1: Width codes for both channel and bus are 00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes. Items are packed little-endian: the first item takes the lowest byte lanes. An entry is pushed in the same cycle as the item that completes the bus width.
- R2: `level_o` equals the stored entry count times the bus width in bytes, and never exceeds 64. It changes on the clock edge that pushes or pops.
- R3: The trigger threshold is N bytes when `cfg_wide_port_i`=0 and 4×N bytes when it is 1, where N = `cfg_rx_lvl_i`. The trigger is met when `level_o` is nonzero and at least the threshold. A level of 0 never raises ready or request.
- R4: With `cfg_dma_en_i`=0 the readiness appears on `rx_ready_o` and `dma_req_o` stays 0. With `cfg_dma_en_i`=1 it appears on `dma_req_o` and `rx_ready_o` stays 0.
- R5: With DMA and `cfg_dma_burst_i`=1, `dma_req_o` needs the trigger met and at least 4 stored entries. The exception is a trailing flush, during which any nonempty store requests single transfers.
- R6: Each accepted item reloads the trailing counter with T = `cfg_trail_cnt_i`. While data waits below the trigger and no item arrives, the flush starts on the (T+1)-th clock edge after the last item. From then on, ready or request stays high while `level_o` is nonzero.
- R7: When the flush starts, a partly packed entry is pushed with its unfilled upper lanes zero.
- R8: A push when the level plus one bus width would exceed 64 bytes is dropped, unless a read frees space in the same cycle. The stored contents are unchanged and `overrun_o` sets and stays set until reset.
- R9: `rd_data_o` shows the oldest entry whenever the store is nonempty, and `rd_en_i` removes it at the clock edge. A read while empty sets a sticky `underrun_o` and shows 0.
- R10: Reset clears the store, the packer, the trailing state and both flags. After reset the level, data, ready, request and flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ch_width_i | input | 2 | Channel item width code |
| cfg_bus_width_i | input | 2 | Bus entry width code |
| cfg_trail_cnt_i | input | 10 | Trailing countdown reload value T |
| cfg_rx_lvl_i | input | 6 | Trigger level N |
| cfg_wide_port_i | input | 1 | 1: threshold 4×N bytes, 0: N bytes |
| cfg_dma_en_i | input | 1 | 1: DMA request mode, 0: interrupt-ready mode |
| cfg_dma_burst_i | input | 1 | 1: four-beat bursts, 0: single transfers |
| sh_valid_i | input | 1 | Received item strobe from the shifter |
| sh_data_i | input | 32 | Received item, right-aligned |
| rd_en_i | input | 1 | Bus read: pop oldest entry |
| rd_data_o | output | 32 | Oldest entry, or 0 when empty |
| level_o | output | 7 | Fill level in bytes |
| rx_ready_o | output | 1 | Interrupt-ready |
| dma_req_o | output | 1 | DMA request |
| overrun_o | output | 1 | Sticky write-while-full flag |
| underrun_o | output | 1 | Sticky read-while-empty flag |

## Verification
A completing item or a read changes `level_o`, `rd_data_o` and the ready and request lines just after the clock edge that samples it. The bench therefore drives each strobe for one cycle from a falling edge and checks at the falling edge that follows that rising edge. The trailing flush lands on the (T+1)-th rising edge after the last item. The bench counts exactly T falling edges and expects ready still low. It then counts one more and expects it high, which pins the countdown to the exact cycle. A read shows its data combinationally before the popping edge, so read values are captured in the cycle the read is driven.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic [1:0] {
    WID_BYTE = 2'b00,
    WID_HALF = 2'b01,
    WID_WORD = 2'b10,
    WID_RSVD = 2'b11
  } width_e;

  // log2 of bytes; reserved code behaves as word
  function automatic logic [1:0] width_shift(logic [1:0] enc);
    case (enc)
      WID_BYTE: return 2'd0;
      WID_HALF: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] width_bytes(logic [1:0] enc);
    return 3'd1 << width_shift(enc);
  endfunction
endpackage

// File: rtl/spi_rx_packer.sv
module spi_rx_packer
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ch_enc_i,
  input  logic [1:0]        bus_enc_i,
  input  logic              item_valid_i,
  input  logic [DATA_W-1:0] item_data_i,
  input  logic              flush_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              pending_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES) + 2;

  logic [DATA_W-1:0] pack_q, merged, item_mask, shifted;
  logic [OFF_W-1:0]  off_q, off_nxt, ch_b, bus_b;
  logic              entry_done;

  assign ch_b  = OFF_W'(width_bytes(ch_enc_i));
  assign bus_b = OFF_W'(width_bytes(bus_enc_i));
  assign off_nxt    = off_q + ch_b;
  assign entry_done = off_nxt >= bus_b;

  always_comb begin
    item_mask = '0;
    for (int b = 0; b < LANES; b++) begin
      if (b < int'(ch_b)) item_mask[b*8 +: 8] = 8'hff;
    end
  end

  assign shifted = (item_data_i & item_mask) << {off_q, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic in_item;
    assign in_item = (OFF_W'(g) >= off_q) && (OFF_W'(g) < off_nxt);
    assign merged[g*8 +: 8] = in_item ? shifted[g*8 +: 8] : pack_q[g*8 +: 8];
  end

  always_comb begin
    push_o      = 1'b0;
    push_data_o = merged;
    if (item_valid_i) begin
      push_o = entry_done;
    end else if (flush_i && off_q != '0) begin
      push_o      = 1'b1;
      push_data_o = pack_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pack_q <= '0;
      off_q  <= '0;
    end else if (item_valid_i) begin
      if (entry_done) begin
        pack_q <= '0;
        off_q  <= '0;
      end else begin
        pack_q <= merged;
        off_q  <= off_nxt;
      end
    end else if (flush_i && off_q != '0) begin
      pack_q <= '0;
      off_q  <= '0;
    end
  end

  assign pending_o = off_q != '0;
endmodule

// File: rtl/spi_rx_store.sv
module spi_rx_store
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH_BYTES = 64,
  localparam int CNT_W      = $clog2(DEPTH_BYTES + 1),
  localparam int LVL_W      = $clog2(DEPTH_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_enc_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              overrun_o,
  output logic              underrun_o
);
  localparam int ENTRIES = DEPTH_BYTES;
  localparam int PTR_W   = $clog2(ENTRIES);

  logic [DATA_W-1:0] mem_q [ENTRIES];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  count_q, cap;
  logic              empty, full, pop_ok, push_ok;

  assign cap     = CNT_W'(DEPTH_BYTES >> width_shift(bus_enc_i));
  assign empty   = count_q == '0;
  assign full    = count_q >= cap;
  assign pop_ok  = pop_i && !empty;
  assign push_ok = push_i && (!full || pop_ok);

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      overrun_o  <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok)  rptr_q <= ptr_inc(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push_i && !push_ok) overrun_o  <= 1'b1;
      if (pop_i && empty)     underrun_o <= 1'b1;
    end
  end

  assign rd_data_o = empty ? '0 : mem_q[rptr_q];
  assign count_o   = count_q;
  assign level_o   = LVL_W'(32'(count_q) << width_shift(bus_enc_i));
endmodule

// File: rtl/spi_rx_trail.sv
module spi_rx_trail #(
  parameter int TRAIL_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TRAIL_W-1:0] reload_i,
  input  logic               item_i,
  input  logic               pending_i,
  input  logic               below_i,
  output logic               flush_o,
  output logic               expire_o
);
  logic [TRAIL_W-1:0] cnt_q;
  logic               flush_q, armed;

  assign armed    = pending_i && below_i && !flush_q;
  assign expire_o = armed && cnt_q == '0 && !item_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (item_i) begin
      cnt_q   <= reload_i;
      flush_q <= 1'b0;
    end else begin
      if (expire_o)                 flush_q <= 1'b1;
      else if (flush_q && !pending_i) flush_q <= 1'b0;
      if (armed && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign flush_o = flush_q;
endmodule

// File: rtl/spi_rx_req.sv
module spi_rx_req #(
  parameter int LVL_W     = 7,
  parameter int CNT_W     = 7,
  parameter int LVL_N_W   = 6,
  parameter int BURST_LEN = 4
) (
  input  logic [LVL_W-1:0]   level_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [LVL_N_W-1:0] lvl_n_i,
  input  logic               wide_i,
  input  logic               dma_en_i,
  input  logic               burst_i,
  input  logic               flush_i,
  output logic               hit_o,
  output logic               rx_ready_o,
  output logic               dma_req_o
);
  localparam int THR_W = LVL_N_W + 2;
  localparam int CMP_W = (THR_W > LVL_W) ? THR_W : LVL_W;

  logic [CMP_W-1:0] thr, lvl;
  logic             nonempty, ready, burst_ok;

  assign thr      = wide_i ? CMP_W'({lvl_n_i, 2'b00}) : CMP_W'(lvl_n_i);
  assign lvl      = CMP_W'(level_i);
  assign nonempty = level_i != '0;
  assign hit_o    = nonempty && lvl >= thr;
  assign ready    = hit_o || (flush_i && nonempty);
  assign burst_ok = (hit_o && 32'(count_i) >= BURST_LEN) || (flush_i && nonempty);

  assign rx_ready_o = !dma_en_i && ready;
  assign dma_req_o  = dma_en_i && (burst_i ? burst_ok : ready);
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int DATA_W      = 32,
  parameter int DEPTH_BYTES = 64,
  parameter int TRAIL_W     = 10,
  parameter int LVL_N_W     = 6,
  parameter int BURST_LEN   = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [1:0]                         cfg_ch_width_i,
  input  logic [1:0]                         cfg_bus_width_i,
  input  logic [TRAIL_W-1:0]                 cfg_trail_cnt_i,
  input  logic [LVL_N_W-1:0]                 cfg_rx_lvl_i,
  input  logic                               cfg_wide_port_i,
  input  logic                               cfg_dma_en_i,
  input  logic                               cfg_dma_burst_i,
  input  logic                               sh_valid_i,
  input  logic [DATA_W-1:0]                  sh_data_i,
  input  logic                               rd_en_i,
  output logic [DATA_W-1:0]                  rd_data_o,
  output logic [$clog2(DEPTH_BYTES+1)-1:0]   level_o,
  output logic                               rx_ready_o,
  output logic                               dma_req_o,
  output logic                               overrun_o,
  output logic                               underrun_o
);
  localparam int LVL_W = $clog2(DEPTH_BYTES + 1);
  localparam int CNT_W = $clog2(DEPTH_BYTES + 1);

  logic              push, pack_pending, flush, expire, hit, pending;
  logic [DATA_W-1:0] push_data;
  logic [CNT_W-1:0]  count;

  spi_rx_packer #(.DATA_W(DATA_W)) u_pack (
    .clk_i, .rst_ni,
    .ch_enc_i    (cfg_ch_width_i),
    .bus_enc_i   (cfg_bus_width_i),
    .item_valid_i(sh_valid_i),
    .item_data_i (sh_data_i),
    .flush_i     (expire),
    .push_o      (push),
    .push_data_o (push_data),
    .pending_o   (pack_pending)
  );

  spi_rx_store #(.DATA_W(DATA_W), .DEPTH_BYTES(DEPTH_BYTES)) u_store (
    .clk_i, .rst_ni,
    .bus_enc_i  (cfg_bus_width_i),
    .push_i     (push),
    .push_data_i(push_data),
    .pop_i      (rd_en_i),
    .rd_data_o  (rd_data_o),
    .count_o    (count),
    .level_o    (level_o),
    .overrun_o  (overrun_o),
    .underrun_o (underrun_o)
  );

  assign pending = (level_o != '0) || pack_pending;

  spi_rx_trail #(.TRAIL_W(TRAIL_W)) u_trail (
    .clk_i, .rst_ni,
    .reload_i (cfg_trail_cnt_i),
    .item_i   (sh_valid_i),
    .pending_i(pending),
    .below_i  (!hit),
    .flush_o  (flush),
    .expire_o (expire)
  );

  spi_rx_req #(
    .LVL_W(LVL_W), .CNT_W(CNT_W), .LVL_N_W(LVL_N_W), .BURST_LEN(BURST_LEN)
  ) u_req (
    .level_i   (level_o),
    .count_i   (count),
    .lvl_n_i   (cfg_rx_lvl_i),
    .wide_i    (cfg_wide_port_i),
    .dma_en_i  (cfg_dma_en_i),
    .burst_i   (cfg_dma_burst_i),
    .flush_i   (flush),
    .hit_o     (hit),
    .rx_ready_o(rx_ready_o),
    .dma_req_o (dma_req_o)
  );
endmodule

// File: rtl/spi_rx_fifo_chk.sv
module spi_rx_fifo_chk
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH_BYTES = 64,
  parameter int BURST_LEN   = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             cfg_dma_en_i,
  input logic                             cfg_dma_burst_i,
  input logic [1:0]                       cfg_bus_width_i,
  input logic [DATA_W-1:0]                rd_data_o,
  input logic [$clog2(DEPTH_BYTES+1)-1:0] level_o,
  input logic                             rx_ready_o,
  input logic                             dma_req_o,
  input logic                             overrun_o,
  input logic                             underrun_o,
  input logic                             flush_i
);
  logic [15:0] burst_floor;
  assign burst_floor = 16'(BURST_LEN) << width_shift(cfg_bus_width_i);

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_o) <= DEPTH_BYTES); // R2
  AST_NO_REQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == '0 |-> !rx_ready_o && !dma_req_o); // R3
  AST_DMA_MASKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dma_en_i |-> !rx_ready_o); // R4
  AST_IRQ_MASKS_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_dma_en_i |-> !dma_req_o); // R4
  AST_BURST_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dma_burst_i && dma_req_o && !flush_i |-> 16'(level_o) >= burst_floor); // R5
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R8
  AST_UDR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o); // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == '0 |-> rd_data_o == '0); // R9
endmodule

bind spi_rx_fifo spi_rx_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH_BYTES(DEPTH_BYTES), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_dma_en_i   (cfg_dma_en_i),
  .cfg_dma_burst_i(cfg_dma_burst_i),
  .cfg_bus_width_i(cfg_bus_width_i),
  .rd_data_o      (rd_data_o),
  .level_o        (level_o),
  .rx_ready_o     (rx_ready_o),
  .dma_req_o      (dma_req_o),
  .overrun_o      (overrun_o),
  .underrun_o     (underrun_o),
  .flush_i        (flush)
);

// File: tb/sim_spi_rx_fifo.sv
module sim_spi_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ch_w = 2'b00, bus_w = 2'b00;
  logic [9:0]  trail = 10'd0;
  logic [5:0]  lvl_n = 6'd0;
  logic        wide = 1'b0, dma_en = 1'b0, burst = 1'b0;
  logic        sv = 1'b0, rd = 1'b0;
  logic [31:0] sd = '0;
  logic [31:0] rdata;
  logic [6:0]  level;
  logic        rdy, req, ovr, udr;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  spi_rx_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_ch_width_i(ch_w), .cfg_bus_width_i(bus_w), .cfg_trail_cnt_i(trail),
    .cfg_rx_lvl_i(lvl_n), .cfg_wide_port_i(wide), .cfg_dma_en_i(dma_en),
    .cfg_dma_burst_i(burst), .sh_valid_i(sv), .sh_data_i(sd), .rd_en_i(rd),
    .rd_data_o(rdata), .level_o(level), .rx_ready_o(rdy), .dma_req_o(req),
    .overrun_o(ovr), .underrun_o(udr)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sv = 1'b0; rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(logic [1:0] c, logic [1:0] b, logic [9:0] t, logic [5:0] n,
                     logic w, logic d, logic bu);
    ch_w = c; bus_w = b; trail = t; lvl_n = n; wide = w; dma_en = d; burst = bu;
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk); sv = 1'b1; sd = d;
    @(negedge clk); sv = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk); rd = 1'b1; d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    cfg(2'b00, 2'b00, 10'd1023, 6'd0, 1'b0, 1'b0, 1'b0);
    do_reset();
    chk("R10 level", 32'(level), 0);
    chk("R10 ready", 32'(rdy), 0);
    chk("R10 req", 32'(req), 0);
    chk("R10 flags", {30'd0, ovr, udr}, 0);
    chk("R10 data", rdata, 0);
    push(32'h5a);
    chk("R3 N=0 nonempty ready", 32'(rdy), 1);
    do_reset();
    chk("R10 level after mid reset", 32'(level), 0);
    pop(d);
    chk("R9 empty read data", d, 0);
    chk("R9 underrun", 32'(udr), 1);
  endtask

  task automatic t_pack();
    logic [31:0] d;
    cfg(2'b00, 2'b10, 10'd1023, 6'd0, 1'b0, 1'b0, 1'b0);
    do_reset();
    push(32'hff11); push(32'h22); push(32'h33);
    chk("R1 partial not pushed", 32'(level), 0);
    push(32'h44);
    chk("R2 word level", 32'(level), 4);
    pop(d);
    chk("R1 byte into word", d, 32'h44332211);
    cfg(2'b01, 2'b10, 10'd1023, 6'd0, 1'b0, 1'b0, 1'b0);
    do_reset();
    push(32'hab1234); push(32'h5678);
    pop(d);
    chk("R1 half into word", d, 32'h56781234);
    cfg(2'b11, 2'b11, 10'd1023, 6'd0, 1'b0, 1'b0, 1'b0);
    do_reset();
    push(32'hcafef00d);
    chk("R1 reserved code as word level", 32'(level), 4);
    chk("R1 reserved code data", rdata, 32'hcafef00d);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    cfg(2'b00, 2'b00, 10'd1023, 6'd8, 1'b0, 1'b0, 1'b0);
    do_reset();
    for (int i = 0; i < 7; i++) push(32'(i));
    chk("R3 below narrow threshold", 32'(rdy), 0);
    push(32'h7);
    chk("R3 at narrow threshold", 32'(rdy), 1);
    chk("R4 irq mode no req", 32'(req), 0);
    pop(d);
    chk("R3 drop below threshold", 32'(rdy), 0);
    cfg(2'b10, 2'b10, 10'd1023, 6'd2, 1'b1, 1'b0, 1'b0);
    do_reset();
    push(32'h1);
    chk("R3 wide 4 bytes below 8", 32'(rdy), 0);
    push(32'h2);
    chk("R3 wide 8 bytes", 32'(rdy), 1);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    cfg(2'b00, 2'b00, 10'd1023, 6'd1, 1'b0, 1'b1, 1'b0);
    do_reset();
    push(32'h1);
    chk("R4 single req", 32'(req), 1);
    chk("R4 dma mode no irq", 32'(rdy), 0);
    cfg(2'b00, 2'b00, 10'd1023, 6'd2, 1'b0, 1'b1, 1'b1);
    do_reset();
    push(32'h1); push(32'h2);
    chk("R5 burst needs 4 entries", 32'(req), 0);
    push(32'h3);
    chk("R5 burst 3 entries", 32'(req), 0);
    push(32'h4);
    chk("R5 burst 4 entries", 32'(req), 1);
    cfg(2'b00, 2'b00, 10'd4, 6'd8, 1'b0, 1'b1, 1'b1);
    do_reset();
    push(32'h1); push(32'h2); push(32'h3);
    repeat (4) @(negedge clk);
    chk("R5 before flush", 32'(req), 0);
    @(negedge clk);
    chk("R5 flush allows short burst", 32'(req), 1);
    pop(d); pop(d); pop(d);
    chk("R5 drained", 32'(req), 0);
  endtask

  task automatic t_trail();
    logic [31:0] d;
    cfg(2'b00, 2'b00, 10'd5, 6'd8, 1'b0, 1'b0, 1'b0);
    do_reset();
    push(32'h61);
    repeat (3) @(negedge clk);
    push(32'h62);
    chk("R6 level 2", 32'(level), 2);
    repeat (5) @(negedge clk);
    chk("R6 reload delays flush", 32'(rdy), 0);
    @(negedge clk);
    chk("R6 flush at T+1", 32'(rdy), 1);
    pop(d);
    chk("R6 still ready while nonempty", 32'(rdy), 1);
    pop(d);
    chk("R6 ready clears when empty", 32'(rdy), 0);
    cfg(2'b00, 2'b10, 10'd3, 6'd8, 1'b0, 1'b0, 1'b0);
    do_reset();
    push(32'haa); push(32'hbb);
    repeat (3) @(negedge clk);
    chk("R7 no push before expiry", 32'(level), 0);
    @(negedge clk);
    chk("R7 partial pushed", 32'(level), 4);
    chk("R7 zero padded", rdata, 32'h0000bbaa);
    chk("R6 ready on partial", 32'(rdy), 1);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    cfg(2'b00, 2'b00, 10'd1023, 6'd0, 1'b0, 1'b0, 1'b0);
    do_reset();
    for (int i = 0; i < 64; i++) push(32'(i));
    chk("R2 full level", 32'(level), 64);
    chk("R8 no overrun yet", 32'(ovr), 0);
    push(32'hee);
    chk("R8 overrun set", 32'(ovr), 1);
    chk("R8 level unchanged", 32'(level), 64);
    for (int i = 0; i < 64; i++) begin
      pop(d);
      if (i == 0 || i == 63) chk("R8 contents kept", d, 32'(i));
    end
    chk("R8 sticky", 32'(ovr), 1);
    chk("R9 no underrun yet", 32'(udr), 0);
    pop(d);
    chk("R9 underrun data", d, 0);
    chk("R9 underrun set", 32'(udr), 1);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_trigger();
    t_dma();
    t_trail();
    t_overrun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule